// File: doc/BRIEF.md
# ECC Error Capture Status Register

This block sits beside a memory ECC decoder and records the first error event the decoder reports. The decoder drives one-cycle pulses for a corrected single-bit error or an uncorrectable multi-bit error, together with the syndrome and the physical address of the access. On the first such pulse, the block latches the upper address bits and the syndrome and sets one sticky status flag. The captured state then stays locked until software clears it.

All state is presented through one 32-bit control/status word with a simple write strobe and a combinational read value. The same word holds three read/write controls: a scrub-disable bit that gates the write-back request raised on corrected reads, an enable that routes a captured multi-bit error to a bus-error line, and an enable that routes a captured single-bit error to an NMI line. Both interrupt outputs are levels. Each stays asserted for as long as its flag and its enable are both set.

Top module: `ecc_err_capture`

## Requirements
- R1: After a synchronous reset every bit of the status word is 0, and `bus_err_o`, `nmi_o` and `scrub_req_o` are low.
- R2: While neither flag is set, a `sbe_pulse` takes effect at the next clock edge. It sets bit 0, loads `err_addr[31:13]` into bits 30:12 and loads `err_syn` into bits 11:4. A `mbe_pulse` does the same but sets bit 1 instead of bit 0. If both pulses arrive in the same cycle, only bit 1 is set.
- R3: A set flag stays set through any write that does not carry 1 in both bit 0 and bit 1. Writing 0 to a flag has no effect on it.
- R4: At most one flag is set at a time. While a flag is set, further error pulses are ignored, and bits 30:4 keep the values of the first capture.
- R5: A write with bits 1:0 = 11 clears both flags at the next edge. A write with only one of the two bits at 1 leaves both flags and the captured fields unchanged. Writing 1s while no flag is set does not set a flag.
- R6: Bit 31 is read/write. `scrub_req_o` follows `sbe_pulse` in the same cycle when bit 31 is 0, and it stays low when bit 31 is 1.
- R7: Bit 3 is read/write. `bus_err_o` is high exactly while bit 3 and the multi-bit flag (bit 1) are both 1.
- R8: Bit 2 is read/write. `nmi_o` is high exactly while bit 2 and the single-bit flag (bit 0) are both 1.
- R9: Writes never change bits 30:4. Those bits change only on a capture or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sbe_pulse | input | 1 | Corrected single-bit error event, one cycle |
| mbe_pulse | input | 1 | Uncorrectable multi-bit error event, one cycle |
| err_syn | input | 8 | Syndrome of the reported error |
| err_addr | input | 32 | Physical address of the failing access |
| reg_wr | input | 1 | Write strobe for the status word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current status word |
| scrub_req_o | output | 1 | Scrub write-back request for a corrected read |
| bus_err_o | output | 1 | Bus-error level for a captured multi-bit error |
| nmi_o | output | 1 | NMI level for a captured single-bit error |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a keep boundary at bit 13 and an 8-bit syndrome. With these values the register layout is exactly the 32-bit word described above, so every field position the requirements state can be checked. Random pulses, addresses and syndromes, combined with writes that clear both flags only some of the time, exercise lock-out, partial clears and enable changes against a reference model. Directed steps cover the reset state, a simultaneous single-bit and multi-bit pulse, an error that arrives in the same cycle as a clear, and the scrub gate.

// File: rtl/ecc_err_capture.sv
module ecc_err_capture #(
  parameter  int ADDR_W = 32,
  parameter  int SYN_W  = 8,
  parameter  int GRAIN  = 13,
  localparam int KEEP_W = ADDR_W - GRAIN,
  localparam int REG_W  = KEEP_W + SYN_W + 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sbe_pulse,
  input  logic              mbe_pulse,
  input  logic [SYN_W-1:0]  err_syn,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              scrub_req_o,
  output logic              bus_err_o,
  output logic              nmi_o
);

  localparam int SCRUB_B = REG_W - 1;
  localparam int BERR_B  = 3;
  localparam int NMI_B   = 2;

  logic              scrub_dis_q, berr_en_q, nmi_en_q;
  logic              sbe_q, mbe_q;
  logic [KEEP_W-1:0] addr_q;
  logic [SYN_W-1:0]  syn_q;

  wire locked  = sbe_q | mbe_q;
  wire clr_req = reg_wr & reg_wdata[1] & reg_wdata[0];
  wire any_err = sbe_pulse | mbe_pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      scrub_dis_q <= 1'b0;
      berr_en_q   <= 1'b0;
      nmi_en_q    <= 1'b0;
      sbe_q       <= 1'b0;
      mbe_q       <= 1'b0;
      addr_q      <= '0;
      syn_q       <= '0;
    end else begin
      if (reg_wr) begin
        scrub_dis_q <= reg_wdata[SCRUB_B];
        berr_en_q   <= reg_wdata[BERR_B];
        nmi_en_q    <= reg_wdata[NMI_B];
      end
      if (locked) begin
        if (clr_req) begin
          sbe_q <= 1'b0;
          mbe_q <= 1'b0;
        end
      end else if (any_err) begin
        mbe_q  <= mbe_pulse;
        sbe_q  <= ~mbe_pulse;
        addr_q <= err_addr[ADDR_W-1:GRAIN];
        syn_q  <= err_syn;
      end
    end
  end

  assign reg_rdata   = {scrub_dis_q, addr_q, syn_q, berr_en_q, nmi_en_q, mbe_q, sbe_q};
  assign scrub_req_o = sbe_pulse & ~scrub_dis_q;
  assign bus_err_o   = mbe_q & berr_en_q;
  assign nmi_o       = sbe_q & nmi_en_q;

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(reg_rdata[0] && reg_rdata[1])); // R4

  AST_MBE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!reg_rdata[0] && !reg_rdata[1] && mbe_pulse) |=> (reg_rdata[1] && !reg_rdata[0])); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    ((reg_rdata[0] || reg_rdata[1]) && !(reg_wr && reg_wdata[1:0] == 2'b11))
      |=> $stable(reg_rdata[1:0])); // R3

  AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[0] || reg_rdata[1]) |=> $stable(reg_rdata[REG_W-2:4])); // R4

  AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ((reg_rdata[0] || reg_rdata[1]) && reg_wr && reg_wdata[1:0] == 2'b11)
      |=> (reg_rdata[1:0] == 2'b00)); // R5

  AST_NO_SPURIOUS_SCRUB: assert property (@(posedge clk) disable iff (rst)
    scrub_req_o |-> (sbe_pulse && !reg_rdata[REG_W-1])); // R6

endmodule

// File: tb/ecc_err_capture_tb.sv
`timescale 1ns/1ps
module ecc_err_capture_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic sbe_pulse = 0, mbe_pulse = 0, reg_wr = 0;
  logic [7:0]  err_syn = 0;
  logic [31:0] err_addr = 0, reg_wdata = 0, reg_rdata;
  logic scrub_req_o, bus_err_o, nmi_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ecc_err_capture u_dut (
    .clk(clk), .rst(rst), .sbe_pulse(sbe_pulse), .mbe_pulse(mbe_pulse),
    .err_syn(err_syn), .err_addr(err_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .scrub_req_o(scrub_req_o), .bus_err_o(bus_err_o), .nmi_o(nmi_o));

  logic m_scrub, m_ben, m_nen, m_sbe, m_mbe;
  logic [18:0] m_addr;
  logic [7:0]  m_syn;

  function automatic logic [31:0] exp_word();
    return {m_scrub, m_addr, m_syn, m_ben, m_nen, m_mbe, m_sbe};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_scrub = 0; m_ben = 0; m_nen = 0; m_sbe = 0; m_mbe = 0; m_addr = 0; m_syn = 0;
  endtask

  task automatic cyc(string tag, logic s, logic m, logic [7:0] syn, logic [31:0] a,
                     logic w, logic [31:0] wd);
    @(negedge clk);
    sbe_pulse = s; mbe_pulse = m; err_syn = syn; err_addr = a; reg_wr = w; reg_wdata = wd;
    #1;
    chk("R6 scrub_req", {31'd0, scrub_req_o}, {31'd0, s & ~m_scrub});
    @(posedge clk);
    if (w) begin m_scrub = wd[31]; m_ben = wd[3]; m_nen = wd[2]; end
    if (m_sbe | m_mbe) begin
      if (w && wd[1:0] == 2'b11) begin m_sbe = 0; m_mbe = 0; end
    end else if (s | m) begin
      m_mbe = m; m_sbe = !m; m_addr = a[31:13]; m_syn = syn;
    end
    #1;
    sbe_pulse = 0; mbe_pulse = 0; reg_wr = 0;
    chk(tag, reg_rdata, exp_word());
    chk("R7 bus_err", {31'd0, bus_err_o}, {31'd0, m_mbe & m_ben});
    chk("R8 nmi", {31'd0, nmi_o}, {31'd0, m_sbe & m_nen});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    chk("R1 reset word", reg_rdata, 32'h0);
    chk("R1 reset outs", {29'd0, scrub_req_o, bus_err_o, nmi_o}, 32'h0);

    cyc("R8 enable nmi", 0, 0, 0, 0, 1, 32'h0000_0004);
    cyc("R2 sbe capture", 1, 0, 8'hA5, 32'hDEADBEEF, 0, 0);
    chk("R2 addr field", {13'd0, reg_rdata[30:12]}, {13'd0, 19'(32'hDEADBEEF >> 13)});
    chk("R2 syn field", {24'd0, reg_rdata[11:4]}, 32'hA5);
    cyc("R4 mbe ignored", 0, 1, 8'h3C, 32'h1234_5678, 0, 0);
    cyc("R3 write zero", 0, 0, 0, 0, 1, 32'h0000_0004);
    cyc("R5 partial 01", 0, 0, 0, 0, 1, 32'h0000_0005);
    cyc("R5 partial 10", 0, 0, 0, 0, 1, 32'h0000_0006);
    cyc("R9 ro bits write", 0, 0, 0, 0, 1, 32'h7FFF_FFF4);
    cyc("R5 full clear", 0, 0, 0, 0, 1, 32'h0000_0007);
    cyc("R7 both pulses", 1, 1, 8'h11, 32'hFFFF_E000, 1, 32'h0000_0008);
    cyc("R5 clear with err", 1, 0, 8'h22, 32'h0000_2000, 1, 32'h0000_000B);
    cyc("R2 err after clear", 1, 0, 8'h33, 32'h8000_4000, 0, 0);
    cyc("R5 clear", 0, 0, 0, 0, 1, 32'h0000_0003);
    cyc("R5 set attempt", 0, 0, 0, 0, 1, 32'h0000_0003);
    cyc("R6 scrub off", 0, 0, 0, 0, 1, 32'h8000_0000);
    cyc("R6 sbe no scrub", 1, 0, 8'h44, 32'h4000_0000, 0, 0);
    cyc("R5 clear", 0, 0, 0, 0, 1, 32'h0000_0003);

    for (int i = 0; i < 3000; i++) begin
      logic s, m, w;
      logic [31:0] wd;
      s = ($urandom % 8) == 0;
      m = ($urandom % 10) == 0;
      w = ($urandom % 4) == 0;
      wd = $urandom;
      cyc("R2 R3 R4 R5 R9 random", s, m, 8'($urandom), $urandom, w, wd);
    end

    @(negedge clk); rst = 1;
    @(posedge clk); #1; model_reset(); rst = 0;
    chk("R1 reset again", reg_rdata, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule